// File: doc/BRIEF.md
# Vector Memory Request Former

This block sits in the decode stage of a vector unit. It accepts one vector load or store instruction word together with the 32-bit value of its base register. For each one it forms a memory request: the effective byte address, a per-byte enable mask over eight 16-bit lanes, the element index, the vector register number, a load/store flag and a request kind. It does not access memory and does not rotate data into lanes. Those steps belong to the stage downstream.

Both sides of the block use valid/ready. An instruction is taken on a cycle where `in_valid` and `in_ready` are both high. The formed request is held in a single output register. While `req_valid` is high and `req_ready` is low, the request stays unchanged and `in_ready` drops, so back-pressure passes straight to the source. `in_ready` is high whenever the output register is empty or is being drained in the same cycle. The block still accepts an instruction whose function code is not recognised, but it produces no request for it.

Top module: `vls_req_former`

## Requirements
- R1: `in_ready` equals `!req_valid || req_ready`. An accepted instruction with a recognised function code appears on the request outputs on the next cycle. A request that is not taken holds every request output unchanged.
- R2: `req_addr` is `in_base` plus the sign-extended 7-bit field `in_insn[6:0]`, shifted left by a scale amount. The scale is the size index `in_insn[12:11]` for function codes 0 to 3, 4 for codes 4, 5 and 11, and 3 for codes 6 to 9.
- R3: The function code is `in_insn[15:11]`. Codes 0 to 3 give kind 0 (sized access). Code 4 gives kind 1 (quad) and code 5 gives kind 2 (rest). Codes 6, 7, 8 and 9 give kinds 3, 4, 5 and 6 (pack, unpack, half, fourth). Code 11 gives kind 7 (transpose). Any other code is accepted and leaves `req_valid` low on the next cycle.
- R4: For kind 0, lane i occupies `req_mask[16i+15:16i]`. With size index 0, a load enables only lane 0 with 0x00FF and a store enables only lane 0 with 0xFF00. Size indices 1, 2 and 3 enable lanes 0, 0–1 and 0–3 respectively with 0xFFFF. All other lanes are 0.
- R5: For kinds 1 and 2, let n be `req_addr[3:0]`. Lanes with index below n/2 are 0 and lanes above n/2 are 0xFFFF. Lane n/2 is 0xFF00 when n is odd and 0xFFFF when n is even.
- R6: For kinds 3 to 7, `req_mask` is all zero.
- R7: `req_store` equals `in_insn[29]` for every kind.
- R8: `req_elem` is `in_insn[10:7]` and `req_vreg` is `in_insn[20:16]`. For kind 7 only, `req_vreg` is `in_insn[20:16] & 5'b11000` and `req_elem` is `in_insn[10:7] >> 1`.
- R9: After reset, `req_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Instruction can be taken |
| in_insn | input | 32 | Instruction word |
| in_base | input | 32 | Base register value |
| req_valid | output | 1 | Request present |
| req_ready | input | 1 | Downstream takes the request |
| req_addr | output | 32 | Effective byte address |
| req_mask | output | 128 | Byte enables, 16 bits per lane |
| req_kind | output | 3 | Request kind (see R3) |
| req_elem | output | 4 | Element index |
| req_vreg | output | 5 | Vector register number |
| req_store | output | 1 | 1 for store, 0 for load |

## Verification
The bench builds the block with its default parameters: eight lanes and a 32-bit address. With these values all sixteen low-address offsets of the quad and rest masks are reachable, including every odd split lane. Directed instructions cover byte loads and stores, each access size, negative offsets, transpose field reduction and unknown function codes. A long random phase then toggles `req_ready` freely, so stalls and acceptance in the same cycle as a drain occur often.

// File: rtl/vls_pkg.sv
`timescale 1ns/1ps
package vls_pkg;
  typedef enum logic [2:0] {
    K_SIZED  = 3'd0,
    K_QUAD   = 3'd1,
    K_REST   = 3'd2,
    K_PACK   = 3'd3,
    K_UNPACK = 3'd4,
    K_HALF   = 3'd5,
    K_FOURTH = 3'd6,
    K_TRANS  = 3'd7
  } req_kind_e;

  localparam int LANE_W   = 16;
  localparam int INSN_W   = 32;
  localparam int OFF_W    = 7;
  localparam int ELEM_W   = 4;
  localparam int VREG_W   = 5;
endpackage

// File: rtl/vls_decode.sv
`timescale 1ns/1ps
module vls_decode
  import vls_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [INSN_W-1:0] insn,
  input  logic [ADDR_W-1:0] base,
  output logic              ok,
  output req_kind_e         kind,
  output logic [1:0]        size,
  output logic [ADDR_W-1:0] addr,
  output logic [ELEM_W-1:0] elem,
  output logic [VREG_W-1:0] vreg,
  output logic              store
);
  localparam int SH_W = 3;

  logic [4:0]        func;
  logic [SH_W-1:0]   shift;
  logic [ADDR_W-1:0] offset;

  assign func   = insn[15:11];
  assign size   = insn[12:11];
  assign store  = insn[29];
  assign offset = {{(ADDR_W-OFF_W){insn[OFF_W-1]}}, insn[OFF_W-1:0]};
  assign addr   = base + (offset << shift);

  always_comb begin
    ok    = 1'b1;
    kind  = K_SIZED;
    shift = '0;
    unique case (func)
      5'd0, 5'd1, 5'd2, 5'd3: begin
        kind  = K_SIZED;
        shift = {1'b0, func[1:0]};
      end
      5'd4:  begin kind = K_QUAD;   shift = 3'd4; end
      5'd5:  begin kind = K_REST;   shift = 3'd4; end
      5'd6:  begin kind = K_PACK;   shift = 3'd3; end
      5'd7:  begin kind = K_UNPACK; shift = 3'd3; end
      5'd8:  begin kind = K_HALF;   shift = 3'd3; end
      5'd9:  begin kind = K_FOURTH; shift = 3'd3; end
      5'd11: begin kind = K_TRANS;  shift = 3'd4; end
      default: ok = 1'b0;
    endcase
  end

  always_comb begin
    if (kind == K_TRANS) begin
      vreg = insn[20:16] & 5'b11000;
      elem = {1'b0, insn[10:8]};
    end else begin
      vreg = insn[20:16];
      elem = insn[10:7];
    end
  end
endmodule

// File: rtl/vls_lane_mask.sv
`timescale 1ns/1ps
module vls_lane_mask
  import vls_pkg::*;
#(
  parameter int LANES = 8
) (
  input  req_kind_e                 kind,
  input  logic [1:0]                size,
  input  logic [$clog2(2*LANES)-1:0] addr_lo,
  input  logic                      store,
  output logic [LANES*LANE_W-1:0]   mask
);
  localparam int LO_W = $clog2(2*LANES);

  int split_lane;
  int sized_lanes;

  assign split_lane  = int'(addr_lo >> 1);
  assign sized_lanes = (size == 2'd0) ? 1 : (1 << (int'(size) - 1));

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [LANE_W-1:0] lane;
    always_comb begin
      lane = '0;
      case (kind)
        K_SIZED: begin
          if (size == 2'd0) begin
            if (i == 0) lane = store ? 16'hFF00 : 16'h00FF;
          end else if (i < sized_lanes) begin
            lane = 16'hFFFF;
          end
        end
        K_QUAD, K_REST: begin
          if (i > split_lane)       lane = 16'hFFFF;
          else if (i == split_lane) lane = addr_lo[0] ? 16'hFF00 : 16'hFFFF;
        end
        default: lane = '0;
      endcase
    end
    assign mask[i*LANE_W +: LANE_W] = lane;
  end
endmodule

// File: rtl/vls_req_former.sv
`timescale 1ns/1ps
module vls_req_former
  import vls_pkg::*;
#(
  parameter int LANES  = 8,
  parameter int ADDR_W = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [31:0]             in_insn,
  input  logic [ADDR_W-1:0]       in_base,
  output logic                    req_valid,
  input  logic                    req_ready,
  output logic [ADDR_W-1:0]       req_addr,
  output logic [LANES*16-1:0]     req_mask,
  output logic [2:0]              req_kind,
  output logic [3:0]              req_elem,
  output logic [4:0]              req_vreg,
  output logic                    req_store
);
  localparam int MASK_W = LANES * LANE_W;
  localparam int LO_W   = $clog2(2*LANES);

  logic              dec_ok;
  req_kind_e         dec_kind;
  logic [1:0]        dec_size;
  logic [ADDR_W-1:0] dec_addr;
  logic [ELEM_W-1:0] dec_elem;
  logic [VREG_W-1:0] dec_vreg;
  logic              dec_store;
  logic [MASK_W-1:0] dec_mask;
  logic              take;

  vls_decode #(.ADDR_W(ADDR_W)) u_decode (
    .insn  (in_insn),
    .base  (in_base),
    .ok    (dec_ok),
    .kind  (dec_kind),
    .size  (dec_size),
    .addr  (dec_addr),
    .elem  (dec_elem),
    .vreg  (dec_vreg),
    .store (dec_store)
  );

  vls_lane_mask #(.LANES(LANES)) u_mask (
    .kind    (dec_kind),
    .size    (dec_size),
    .addr_lo (dec_addr[LO_W-1:0]),
    .store   (dec_store),
    .mask    (dec_mask)
  );

  assign in_ready = !req_valid || req_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_valid <= 1'b0;
      req_addr  <= '0;
      req_mask  <= '0;
      req_kind  <= '0;
      req_elem  <= '0;
      req_vreg  <= '0;
      req_store <= 1'b0;
    end else if (take) begin
      req_valid <= dec_ok;
      req_addr  <= dec_addr;
      req_mask  <= dec_mask;
      req_kind  <= dec_kind;
      req_elem  <= dec_elem;
      req_vreg  <= dec_vreg;
      req_store <= dec_store;
    end else if (req_ready) begin
      req_valid <= 1'b0;
    end
  end

  // R1
  hold_stalled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_addr) &&
      $stable(req_mask) && $stable(req_kind) && $stable(req_vreg));

  // R3
  drop_unknown_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && !dec_ok |=> !req_valid);

  // R4
  sized_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_kind == 3'd0 |->
      $countones(req_mask) inside {8, 16, 32, 64});

  // R5
  split_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && (req_kind == 3'd1 || req_kind == 3'd2) |->
      $countones(req_mask) == MASK_W - 8 * int'(req_addr[LO_W-1:0]));

  // R6
  empty_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_kind >= 3'd3 |-> req_mask == '0);

  // R8
  trans_vreg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_kind == 3'd7 |-> req_vreg[2:0] == 3'd0 && !req_elem[3]);
endmodule

// File: tb/vls_req_former_bench.sv
`timescale 1ns/1ps
module vls_req_former_bench;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [31:0]  in_insn = '0;
  logic [31:0]  in_base = '0;
  logic         req_valid;
  logic         req_ready = 1'b0;
  logic [31:0]  req_addr;
  logic [127:0] req_mask;
  logic [2:0]   req_kind;
  logic [3:0]   req_elem;
  logic [4:0]   req_vreg;
  logic         req_store;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic         m_valid = 1'b0;
  logic [31:0]  m_addr;
  logic [127:0] m_mask;
  int           m_kind;
  int           m_elem, m_vreg, m_store;

  always #2.5 clk = ~clk;

  vls_req_former u_vls_req_former (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_insn(in_insn), .in_base(in_base), .req_valid(req_valid),
    .req_ready(req_ready), .req_addr(req_addr), .req_mask(req_mask),
    .req_kind(req_kind), .req_elem(req_elem), .req_vreg(req_vreg),
    .req_store(req_store)
  );

  task automatic chk(input bit ok, input string tag, input logic [127:0] act,
                     input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int ref_kind(input int f);
    if (f <= 3) return 0;
    if (f == 4) return 1;
    if (f == 5) return 2;
    if (f >= 6 && f <= 9) return f - 3;
    if (f == 11) return 7;
    return -1;
  endfunction

  function automatic int ref_scale(input int f);
    if (f <= 3) return f;
    if (f == 4 || f == 5 || f == 11) return 4;
    return 3;
  endfunction

  function automatic logic [127:0] ref_mask(input int kind, input int sz,
                                            input int st, input int n);
    logic [127:0] m = '0;
    for (int i = 0; i < 8; i++) begin
      logic [15:0] v = 16'h0000;
      if (kind == 0) begin
        int cnt = (sz == 0) ? 1 : (sz == 1 ? 1 : (sz == 2 ? 2 : 4));
        if (i < cnt) v = 16'hFFFF;
        if (sz == 0 && i == 0) v = st ? 16'hFF00 : 16'h00FF;
      end else if (kind == 1 || kind == 2) begin
        if (2 * i + 1 < n) v = 16'h0000;
        else if (2 * i + 1 == n) v = 16'hFF00;
        else v = 16'hFFFF;
      end
      m[i*16 +: 16] = v;
    end
    return m;
  endfunction

  task automatic step(input bit v, input logic [31:0] insn,
                      input logic [31:0] base, input bit rdy);
    bit exp_rdy;
    int k, f, off;
    in_valid = v; in_insn = insn; in_base = base; req_ready = rdy;
    #1;
    exp_rdy = !m_valid || rdy;
    chk(in_ready == exp_rdy, "R1 in_ready", 128'(in_ready), 128'(exp_rdy));
    if (m_valid && rdy) m_valid = 1'b0;
    if (v && exp_rdy) begin
      f = int'(insn[15:11]);
      k = ref_kind(f);
      if (k < 0) m_valid = 1'b0;
      else begin
        off = int'(insn[6:0]);
        if (off >= 64) off = off - 128;
        m_valid = 1'b1;
        m_kind  = k;
        m_addr  = base + 32'(off * (1 << ref_scale(f)));
        m_mask  = ref_mask(k, int'(insn[12:11]), int'(insn[29]),
                           int'(m_addr[3:0]));
        m_store = int'(insn[29]);
        m_vreg  = int'(insn[20:16]);
        m_elem  = int'(insn[10:7]);
        if (k == 7) begin
          m_vreg = (m_vreg / 8) * 8;
          m_elem = m_elem / 2;
        end
      end
    end
    @(posedge clk);
    @(negedge clk);
    chk(req_valid == m_valid, "R3 req_valid", 128'(req_valid), 128'(m_valid));
    if (m_valid && req_valid) begin
      chk(req_addr == m_addr, "R2 addr", 128'(req_addr), 128'(m_addr));
      chk(int'(req_kind) == m_kind, "R3 kind", 128'(req_kind), 128'(m_kind));
      if (m_kind == 0)
        chk(req_mask == m_mask, "R4 sized mask", req_mask, m_mask);
      else if (m_kind <= 2)
        chk(req_mask == m_mask, "R5 split mask", req_mask, m_mask);
      else
        chk(req_mask == m_mask, "R6 zero mask", req_mask, m_mask);
      chk(int'(req_store) == m_store, "R7 store", 128'(req_store), 128'(m_store));
      chk(int'(req_vreg) == m_vreg && int'(req_elem) == m_elem, "R8 vreg/elem",
          {req_vreg, req_elem}, {5'(m_vreg), 4'(m_elem)});
    end
  endtask

  function automatic logic [31:0] mk(input int f, input bit st, input int vr,
                                     input int el, input int off);
    logic [31:0] w = '0;
    w[29] = st; w[20:16] = 5'(vr); w[15:11] = 5'(f);
    w[10:7] = 4'(el); w[6:0] = 7'(off);
    return w;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(req_valid == 1'b0, "R9 reset valid", 128'(req_valid), 128'(0));
    chk(in_ready == 1'b1, "R9 reset ready", 128'(in_ready), 128'(1));
    @(negedge clk);
    // R4 byte load and byte store, then each larger size
    step(1, mk(0, 0, 3, 5, 1), 32'h100, 1);
    step(1, mk(0, 1, 3, 5, 1), 32'h100, 1);
    step(1, mk(1, 0, 4, 2, 7'h7F), 32'h200, 1);
    step(1, mk(2, 1, 4, 2, 3), 32'h200, 1);
    step(1, mk(3, 0, 9, 1, 7'h40), 32'h1000, 1);
    // R5 quad/rest across every address offset
    for (int n = 0; n < 16; n++) begin
      step(1, mk(4, n % 2, 1, 0, 0), 32'h300 + 32'(n), 1);
      step(1, mk(5, 0, 1, 0, 1), 32'h300 + 32'(n), 1);
    end
    // R6 pack group and transpose; R8 field reduction
    for (int f = 6; f <= 9; f++) step(1, mk(f, 1, 17, 9, 2), 32'h40, 1);
    step(1, mk(11, 0, 31, 15, 7'h7E), 32'h800, 1);
    // R3 unknown codes accepted without a request
    step(1, mk(10, 0, 1, 1, 1), 32'h0, 1);
    step(1, mk(31, 0, 1, 1, 1), 32'h0, 1);
    // R1 stall holds request
    step(1, mk(2, 0, 2, 2, 2), 32'h500, 0);
    step(1, mk(3, 0, 2, 2, 2), 32'h600, 0);
    step(0, 32'h0, 32'h0, 1);
    for (int c = 0; c < 6000; c++) begin
      logic [31:0] w = $urandom;
      if ($urandom_range(0, 3) != 0) w[15:11] = 5'($urandom_range(0, 12));
      step($urandom_range(0, 3) != 0, w, $urandom, $urandom_range(0, 2) != 0);
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule